// File: doc/BRIEF.md
# Packed SIMD Signed Adder

This block adds two 32-bit words lane by lane, treating each word either as two signed 16-bit lanes or as four signed 8-bit lanes. One segmented carry chain, cut into byte segments, serves both lane widths. A carry is passed between segments only when those segments belong to the same 16-bit lane, so no sum leaks into a neighbouring lane.

An optional halving mode returns each lane's average rounded toward minus infinity. The sum is kept at one bit wider than the lane, so this result can never overflow.

The block sits in an execute stage behind the decoder. Each transaction carries a valid strobe and a condition-pass bit. A transaction whose condition fails leaves the result register untouched, and no flags exist to update. The result and its valid flag are registered, so the latency is one cycle.

Top module: `packed_sadd`

## Requirements
- R1: With sizeSel=0 and halveSel=0, each 16-bit lane of result (bits 15:0 and 31:16) equals the sum of the matching lanes of opA and opB modulo 2^16, with no carry passing from bit 15 into bit 16.
- R2: With sizeSel=1 and halveSel=0, each byte lane of result (bits 8k+7:8k, k=0..3) equals the sum of the matching bytes modulo 2^8, with no carry passing between bytes.
- R3: With sizeSel=0 and halveSel=1, each 16-bit lane of result equals floor((a+b)/2), where a and b are the signed lane values. The result is exact for every input and never overflows; for example 0x8000+0x8000 gives 0x8000.
- R4: With sizeSel=1 and halveSel=1, each byte lane of result equals floor((a+b)/2) of the signed byte values. For example 0x80+0x80 gives 0x80, and 0xFF+0x00 gives 0xFF.
- R5: A transaction accepted at a rising clock edge (inValid=1 and condPass=1) is visible on result at that same edge, giving a latency of one cycle.
- R6: resValid equals, one cycle later, the value inValid AND condPass had at the previous rising edge.
- R7: When inValid=0 or condPass=0 at a rising edge, result keeps its previous value, whatever the operands and selects are.
- R8: A synchronous active-high rst clears result to zero and resValid to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Transaction strobe |
| condPass | input | 1 | Condition result; 0 suppresses the write |
| sizeSel | input | 1 | Lane size: 0 = two 16-bit lanes, 1 = four 8-bit lanes |
| halveSel | input | 1 | 1 = halve each lane sum |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| resValid | output | 1 | Result register holds a newly written value |
| result | output | 32 | Registered lane-wise result |

## Verification
The bench builds the block with its default parameters: a 32-bit word cut into 8-bit segments. With these values both lane modes are exercised, and so are the segment boundary that links two bytes into one 16-bit lane and the lane-top bit that the halving shift uses. Operands are chosen with carry-outs of 0xFF and 0xFFFF and with both signs at their extremes. This puts carry isolation and the overflow-free halving at the lane edges within reach. The bench also alternates modes from one transaction to the next.

// File: rtl/psadd_pkg.sv
package psadd_pkg;

  // Number of narrow segments that make up one wide lane.
  localparam int unsigned SEGS_PER_WIDE = 2;

  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic capture;  // write the result register this edge
    logic narrow;   // 1: every segment is its own lane
    logic halve;    // 1: arithmetic halving of each lane sum
  } ctrlStrobes_t;

endpackage

// File: rtl/psadd_ctrl.sv
module psadd_ctrl
  import psadd_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         condPass,
  input  logic         sizeSel,
  input  logic         halveSel,
  output ctrlStrobes_t strobes,
  output logic         outValid
);

  logic acceptNow;

  assign acceptNow       = inValid & condPass;
  assign strobes.capture = acceptNow;
  assign strobes.narrow  = sizeSel;
  assign strobes.halve   = halveSel;

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= acceptNow;
  end

  // R6: valid flag tracks accepted transactions one cycle later
  p_valid_set_r6: assert property (@(posedge clk) disable iff (rst)
    (inValid && condPass) |=> outValid);
  p_valid_clear_r6: assert property (@(posedge clk) disable iff (rst)
    !(inValid && condPass) |=> !outValid);
  // R8: reset clears the valid flag
  p_reset_valid_r8: assert property (@(posedge clk)
    rst |=> !outValid);

endmodule

// File: rtl/psadd_dp.sv
module psadd_dp
  import psadd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result
);

  localparam int unsigned NUM_SEG = DATA_W / SEG_W;
  localparam int unsigned WIDE_W  = SEG_W * SEGS_PER_WIDE;

  logic [NUM_SEG-1:0][SEG_W-1:0] segSum;
  logic [NUM_SEG-1:0]            laneTop;   // sign bit of the widened lane sum
  logic [NUM_SEG-1:0][SEG_W-1:0] segHalf;
  logic [DATA_W-1:0]             wrapWord;
  logic [DATA_W-1:0]             halfWord;

  // Segmented carry chain: a carry crosses into a segment only when that
  // segment continues a wide lane.
  always_comb begin
    logic carry;
    logic cin;
    logic [SEG_W-1:0] segA;
    logic [SEG_W-1:0] segB;
    logic [SEG_W:0]   wide;
    carry = 1'b0;
    for (int i = 0; i < int'(NUM_SEG); i++) begin
      segA = opA[i*SEG_W +: SEG_W];
      segB = opB[i*SEG_W +: SEG_W];
      cin  = (strobes.narrow || ((i % SEGS_PER_WIDE) == 0)) ? 1'b0 : carry;
      wide = {1'b0, segA} + {1'b0, segB} + {{SEG_W{1'b0}}, cin};
      segSum[i]  = wide[SEG_W-1:0];
      carry      = wide[SEG_W];
      laneTop[i] = segA[SEG_W-1] ^ segB[SEG_W-1] ^ wide[SEG_W];
    end
  end

  // Halving: shift each segment right, feeding in the neighbour's LSB inside
  // a wide lane, or the lane's extended sign bit at the lane top.
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_half
    logic isLaneTop;
    logic shiftIn;
    if (g == NUM_SEG - 1) begin : g_last
      assign isLaneTop = 1'b1;
      assign shiftIn   = laneTop[g];
    end else begin : g_inner
      assign isLaneTop = strobes.narrow || ((g % SEGS_PER_WIDE) == SEGS_PER_WIDE - 1);
      assign shiftIn   = isLaneTop ? laneTop[g] : segSum[g+1][0];
    end
    assign segHalf[g] = {shiftIn, segSum[g][SEG_W-1:1]};
    assign wrapWord[g*SEG_W +: SEG_W] = segSum[g];
    assign halfWord[g*SEG_W +: SEG_W] = segHalf[g];
  end

  always_ff @(posedge clk) begin
    if (rst)                  result <= '0;
    else if (strobes.capture) result <= strobes.halve ? halfWord : wrapWord;
  end

  // R7: no write without an accepted transaction
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !strobes.capture |=> $stable(result));
  // R1: low wide lane wraps at its own width
  p_wide_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (strobes.capture && !strobes.narrow && !strobes.halve) |=>
      result[WIDE_W-1:0] == WIDE_W'($past(opA[WIDE_W-1:0]) + $past(opB[WIDE_W-1:0])));
  // R2: low byte lane wraps at its own width
  p_narrow_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (strobes.capture && strobes.narrow && !strobes.halve) |=>
      result[SEG_W-1:0] == SEG_W'($past(opA[SEG_W-1:0]) + $past(opB[SEG_W-1:0])));
  // R3/R4: average of equal operands is the operand itself, in any lane size
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (strobes.capture && strobes.halve && (opA == opB)) |=> result == $past(opA));
  // R8: reset clears the result
  p_reset_result_r8: assert property (@(posedge clk)
    rst |=> result == '0);

endmodule

// File: rtl/packed_sadd.sv
module packed_sadd
  import psadd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              condPass,
  input  logic              sizeSel,
  input  logic              halveSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              resValid,
  output logic [DATA_W-1:0] result
);

  ctrlStrobes_t strobes;

  psadd_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .condPass (condPass),
    .sizeSel  (sizeSel),
    .halveSel (halveSel),
    .strobes  (strobes),
    .outValid (resValid)
  );

  psadd_dp #(.DATA_W(DATA_W), .SEG_W(SEG_W)) i_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .result  (result)
  );

  // R5: an accepted transaction raises valid exactly one cycle later
  p_latency_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(resValid) |-> $past(inValid && condPass));

endmodule

// File: tb/test_packed_sadd.sv
module test_packed_sadd;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid, condPass, sizeSel, halveSel;
  logic [31:0] opA, opB;
  logic        resValid;
  logic [31:0] result;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  packed_sadd i_packed_sadd (
    .clk(clk), .rst(rst), .inValid(inValid), .condPass(condPass),
    .sizeSel(sizeSel), .halveSel(halveSel), .opA(opA), .opB(opB),
    .resValid(resValid), .result(result)
  );

  // Stimulus table: {sizeSel, halveSel, opA, opB}
  localparam logic [65:0] VEC [12] = '{
    {1'b0, 1'b0, 32'h1234_5678, 32'h1111_2222},
    {1'b0, 1'b0, 32'h7FFF_8000, 32'h0001_FFFF},
    {1'b1, 1'b0, 32'h7F80_FF01, 32'h0180_0101},
    {1'b1, 1'b0, 32'hDEAD_BEEF, 32'hCAFE_F00D},
    {1'b0, 1'b1, 32'h8000_7FFF, 32'h8000_7FFF},
    {1'b0, 1'b1, 32'hFFFF_0003, 32'h0000_FFFC},
    {1'b1, 1'b1, 32'h8080_7F7F, 32'h8080_7F7F},
    {1'b1, 1'b1, 32'hFF01_03FD, 32'h0000_0000},
    {1'b0, 1'b0, 32'hA5A5_5A5A, 32'h5A5A_A5A5},
    {1'b1, 1'b1, 32'h1357_9BDF, 32'hF0E1_D2C3},
    {1'b0, 1'b1, 32'hC001_4000, 32'hBFFF_3FFF},
    {1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0101_0101}
  };

  // Model straight from R1-style lane arithmetic on signed integers
  function automatic logic [31:0] refSum(input logic [31:0] a, input logic [31:0] b,
                                         input logic sz, input logic hv);
    int w;
    int lanes;
    logic [31:0] r;
    w = sz ? 8 : 16;
    lanes = 32 / w;
    r = '0;
    for (int k = 0; k < lanes; k++) begin
      int mask;
      int va;
      int vb;
      int s;
      mask = (1 << w) - 1;
      va = int'(a >> (k*w)) & mask;
      vb = int'(b >> (k*w)) & mask;
      if (va >= (1 << (w-1))) va = va - (1 << w);
      if (vb >= (1 << (w-1))) vb = vb - (1 << w);
      s = va + vb;
      if (hv) s = s >>> 1;
      r = r | ((32'(s) & 32'(mask)) << (k*w));
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic c, input logic sz, input logic hv,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    inValid = v; condPass = c; sizeSel = sz; halveSel = hv; opA = a; opB = b;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; inValid = 1'b1; condPass = 1'b1; sizeSel = 1'b0; halveSel = 1'b0;
    opA = 32'hFFFF_FFFF; opB = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R8 reset result", result, 32'h0);
    check("R8 reset valid", {31'b0, resValid}, 32'h0);
    rst = 1'b0;

    // Table walk, tagged by mode: R1 / R2 / R3 / R4
    for (int i = 0; i < 12; i++) begin
      logic [65:0] v;
      v = VEC[i];
      drive(1'b1, 1'b1, v[65], v[64], v[63:32], v[31:0]);
      check(v[65] ? (v[64] ? "R4 table" : "R2 table") : (v[64] ? "R3 table" : "R1 table"),
            result, refSum(v[63:32], v[31:0], v[65], v[64]));
      check("R6 valid after accept", {31'b0, resValid}, 32'h1);
    end

    // R1: no carry from bit 15 into bit 16
    drive(1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_FFFF, 32'h0000_0001);
    check("R1 lane isolation", result, 32'h0000_0000);
    // R1 vs R2 on the same operands: wide lanes link bytes, narrow do not
    drive(1'b1, 1'b1, 1'b0, 1'b0, 32'h00FF_00FF, 32'h0001_0001);
    check("R1 intra-lane carry", result, 32'h0100_0100);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 32'h00FF_00FF, 32'h0001_0001);
    check("R2 byte isolation", result, 32'h0000_0000);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 32'h7F7F_7F7F, 32'h0101_0101);
    check("R2 signed wrap", result, 32'h8080_8080);
    // R3: extremes
    drive(1'b1, 1'b1, 1'b0, 1'b1, 32'h8000_7FFF, 32'h8000_7FFF);
    check("R3 extremes", result, 32'h8000_7FFF);
    drive(1'b1, 1'b1, 1'b0, 1'b1, 32'hFFFF_0001, 32'h0000_0000);
    check("R3 floor rounding", result, 32'hFFFF_0000);
    // R4: extremes and floor
    drive(1'b1, 1'b1, 1'b1, 1'b1, 32'h8080_8080, 32'h8080_8080);
    check("R4 most negative", result, 32'h8080_8080);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 32'hFF01_7F80, 32'h0000_7F7F);
    check("R4 mixed", result, 32'hFF00_7FFF);

    // R5: exact latency — drive at negedge, sample just after next posedge
    @(negedge clk);
    inValid = 1'b1; condPass = 1'b1; sizeSel = 1'b0; halveSel = 1'b0;
    opA = 32'h0001_0001; opB = 32'h0002_0002;
    @(posedge clk); #1;
    check("R5 one-cycle latency", result, 32'h0003_0003);
    check("R5 valid with data", {31'b0, resValid}, 32'h1);

    // R7: failed condition holds result, R6 drops valid
    drive(1'b1, 1'b0, 1'b1, 1'b1, 32'h1111_1111, 32'h2222_2222);
    check("R7 condition fail holds", result, 32'h0003_0003);
    check("R6 valid low on fail", {31'b0, resValid}, 32'h0);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 32'h4444_4444, 32'h4444_4444);
    check("R7 no-valid holds", result, 32'h0003_0003);
    check("R6 valid low idle", {31'b0, resValid}, 32'h0);

    // R8: reset mid-stream
    @(negedge clk);
    rst = 1'b1; inValid = 1'b1; condPass = 1'b1;
    @(negedge clk);
    check("R8 reset clears result", result, 32'h0);
    check("R8 reset clears valid", {31'b0, resValid}, 32'h0);
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule